// File: doc/BRIEF.md
# Dual-Output Maskable Interrupt Router

This block gathers up to thirty-two level-sensitive request lines from peripherals and steers each one to one of two processor inputs: an ordinary interrupt request or a fast interrupt request. Each source has a steering bit, which picks the output, and an enable bit, which lets it through or holds it back. A small register bus lets software set the enables, the steering and one control bit. The same bus gives read-only views of the raw active sources, of the enabled sources steered to the ordinary output, and of the enabled sources steered to the fast output.

Some bit positions are not wired to any source. Those bits always read as zero and ignore writes. The block also has a wake-up output for a core that is idling. A control bit decides whether wake-up looks at every active source or only at the enabled ones. Request lines are sampled once on the clock before any logic uses them, so every view and output is built from the same registered snapshot.

Top module: `dual_irq_router`

## Requirements
- R1: Only source positions 8 to 14 and 17 to 31 exist (valid pattern 0xFFFE7F00). Every other bit reads as 0 in all views and in the enable and steering registers, and a reserved bit on the source input has no effect on any output.
- R2: Enable register at byte offset 0x04. A 1 lets the source reach the interrupt outputs. A 0 keeps it off both outputs.
- R3: Steering register at offset 0x08. A 0 sends the source to `irq_o` and a 1 sends it to `fiq_o`.
- R4: The raw view at offset 0x10 shows every active valid source whatever the enables are. A bit clears by itself once its line drops.
- R5: The ordinary view at offset 0x00 reads source AND enable AND NOT steering. The fast view at offset 0x0C reads source AND enable AND steering.
- R6: `irq_o` is the OR of the ordinary view and `fiq_o` is the OR of the fast view.
- R7: Control bit 0 at offset 0x14 sets wake-up. When it is 0, any active valid source wakes the core and the enables are ignored. When it is 1, only enabled active sources wake it.
- R8: `wake_o` is high only while `idle_i` is high.
- R9: The enable, steering and control registers reset to 0. Writes to offsets 0x00, 0x0C and 0x10, and to unmapped offsets, change no register. Unmapped offsets read 0.
- R10: A change on `src_i` shows in the views and outputs right after the next rising clock edge. A register write takes effect at the edge on which `bus_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Level-sensitive request lines |
| bus_addr | input | 5 | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Ordinary interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| idle_i | input | 1 | Core is in idle mode |
| wake_o | output | 1 | Wake-up request to the idling core |

## Verification
There is one register between a source line and every view and output. The bench therefore changes `src_i` just after a falling edge and lets one rising edge pass. It then reads back all six offsets and the three outputs during the low half of the following clock, comparing them against a model updated at that same edge.

Register writes are held across exactly one rising edge, and the model applies them at that edge. Read data and `wake_o` are combinational from the registered state and `idle_i`. For that reason they are sampled a fraction of a nanosecond after their address or `idle_i` changes, and always before the next rising edge.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
// Shared constants for the dual-output interrupt router.
// Assumes a 32-bit data path and word-aligned byte offsets.
package intc_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    // Positions that have a real source behind them.
    localparam logic [DATA_W-1:0] SRC_VALID = 32'hFFFE_7F00;
    localparam logic [ADDR_W-1:0] OFF_NPEND = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_LEVEL = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_FPEND = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_RAW   = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h14;
endpackage

// File: rtl/intc_src_sample.sv
`timescale 1ns/1ps
// Registers the request lines once per clock and drops reserved positions.
// Assumes the lines are already synchronous to clk.
module intc_src_sample #(
    parameter int W = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] src_q
);
    // Capture the valid source lines every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i & VALID;
    end

    AST_SRC_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q & ~VALID) == '0);  // R1
    AST_SRC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> src_q == ($past(src_i) & VALID));  // R10
endmodule

// File: rtl/intc_cfg_regs.sv
`timescale 1ns/1ps
// Holds the software-written enable, steering and control registers.
// Assumes one write per cycle. Reserved bits are never stored.
module intc_cfg_regs
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] level_q,
    output logic              ctrl_q
);
    // Update whichever writable register the offset selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            level_q <= '0;
            ctrl_q  <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == OFF_MASK)  mask_q  <= bus_wdata & SRC_VALID;
            if (bus_addr == OFF_LEVEL) level_q <= bus_wdata & SRC_VALID;
            if (bus_addr == OFF_CTRL)  ctrl_q  <= bus_wdata[0];
        end
    end

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_MASK) |=> mask_q == ($past(bus_wdata) & SRC_VALID));  // R2
    AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != OFF_MASK && bus_addr != OFF_LEVEL && bus_addr != OFF_CTRL)
        |=> ($stable(mask_q) && $stable(level_q) && $stable(ctrl_q)));  // R9
endmodule

// File: rtl/intc_route.sv
`timescale 1ns/1ps
// Splits enabled sources between the two outputs and forms the wake request.
// Purely combinational. Inputs come from registers in the sibling modules.
module intc_route #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_q,
    input  logic [W-1:0] mask_q,
    input  logic [W-1:0] level_q,
    input  logic         ctrl_q,
    input  logic         idle_i,
    output logic [W-1:0] norm_pend,
    output logic [W-1:0] fast_pend,
    output logic         irq_o,
    output logic         fiq_o,
    output logic         wake_o
);
    logic [W-1:0] gated;

    // Per-source gating and steering.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gated[i]     = src_q[i] & mask_q[i];
        assign norm_pend[i] = gated[i] & ~level_q[i];
        assign fast_pend[i] = gated[i] &  level_q[i];
    end

    // Output requests and idle wake qualification.
    always_comb begin
        irq_o  = |norm_pend;
        fiq_o  = |fast_pend;
        wake_o = idle_i & (ctrl_q ? |gated : |src_q);
    end

    AST_MASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (!irq_o && !fiq_o));  // R2
    AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_pend & fast_pend) == '0);  // R3
    AST_WAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_i |-> !wake_o);  // R8
    AST_WAKE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (src_q != '0));  // R7
endmodule

// File: rtl/dual_irq_router.sv
`timescale 1ns/1ps
// Top of the dual-output interrupt router: sampling, configuration,
// steering and the read-back multiplexer. Reads are combinational.
module dual_irq_router
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              fiq_o,
    input  logic              idle_i,
    output logic              wake_o
);
    logic [DATA_W-1:0] src_q, mask_q, level_q, norm_pend, fast_pend;
    logic              ctrl_q;

    intc_src_sample #(.W(DATA_W), .VALID(SRC_VALID)) u_sample (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .src_q(src_q));

    intc_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .mask_q(mask_q), .level_q(level_q), .ctrl_q(ctrl_q));

    intc_route #(.W(DATA_W)) u_route (
        .clk(clk), .rst_n(rst_n), .src_q(src_q), .mask_q(mask_q),
        .level_q(level_q), .ctrl_q(ctrl_q), .idle_i(idle_i),
        .norm_pend(norm_pend), .fast_pend(fast_pend),
        .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o));

    // Select the register view addressed on the bus.
    always_comb begin
        case (bus_addr)
            OFF_NPEND: bus_rdata = norm_pend;
            OFF_MASK:  bus_rdata = mask_q;
            OFF_LEVEL: bus_rdata = level_q;
            OFF_FPEND: bus_rdata = fast_pend;
            OFF_RAW:   bus_rdata = src_q;
            OFF_CTRL:  bus_rdata = {{(DATA_W-1){1'b0}}, ctrl_q};
            default:   bus_rdata = '0;
        endcase
    end

    AST_RDATA_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != OFF_CTRL) |-> (bus_rdata & ~SRC_VALID) == '0);  // R1
    AST_IRQ_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> (src_q & mask_q) != '0);  // R6
endmodule

// File: tb/dual_irq_router_test.sv
`timescale 1ns/1ps
module dual_irq_router_test;
    localparam logic [31:0] VALID = 32'hFFFE_7F00;

    logic        clk = 0, rst_n = 0, bus_wr = 0, idle_i = 0;
    logic [31:0] src_i = '0, bus_wdata = '0, bus_rdata;
    logic [4:0]  bus_addr = '0;
    logic        irq_o, fiq_o, wake_o;

    logic [31:0] m_src = '0, m_mask = '0, m_level = '0;
    logic        m_ctrl = 0;
    int errors = 0, checks = 0;
    bit done = 0;

    dual_irq_router uut (.clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o), .idle_i(idle_i), .wake_o(wake_o));

    always #5 clk = ~clk;

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        case (a)
            5'h00: return m_src & m_mask & ~m_level;
            5'h04: return m_mask;
            5'h08: return m_level;
            5'h0C: return m_src & m_mask & m_level;
            5'h10: return m_src;
            5'h14: return {31'd0, m_ctrl};
            default: return '0;
        endcase
    endfunction

    function automatic logic exp_wake();
        return idle_i & (m_ctrl ? |(m_src & m_mask) : |m_src);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called in the low clock phase: all views plus outputs.
    task automatic check_all(input string tag);
        for (int k = 0; k < 7; k++) begin
            bus_addr = (k == 6) ? 5'h18 : 5'(k * 4);
            #0.4;
            chk({tag, " read"}, bus_rdata, exp_read(bus_addr));
        end
        chk({tag, " R6 irq"}, {31'd0, irq_o}, {31'd0, |(m_src & m_mask & ~m_level)});
        chk({tag, " R6 fiq"}, {31'd0, fiq_o}, {31'd0, |(m_src & m_mask & m_level)});
        chk({tag, " R7/R8 wake"}, {31'd0, wake_o}, {31'd0, exp_wake()});
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge clk);
        if (a == 5'h04) m_mask  = d & VALID;
        if (a == 5'h08) m_level = d & VALID;
        if (a == 5'h14) m_ctrl  = d[0];
        #1 bus_wr = 0;
    endtask

    task automatic step(input logic [31:0] s, input logic idl, input string tag);
        @(negedge clk);
        src_i = s; idle_i = idl;
        @(posedge clk);
        m_src = s & VALID;
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check_all("R9 reset");
        // R1: reserved source lines only
        step(32'h0001_80FF, 1'b1, "R1 reserved src");
        wr(5'h04, 32'hFFFF_FFFF);
        @(negedge clk); bus_addr = 5'h04; #0.4;
        chk("R1 mask reserved", bus_rdata, VALID);
        // R7: ctrl 0 wakes on unmasked source
        wr(5'h04, 32'h0);
        step(32'h0000_0100, 1'b1, "R7 dim0 wake");
        wr(5'h14, 32'h1);
        step(32'h0000_0100, 1'b1, "R7 dim1 no wake");
        step(32'h0000_0100, 1'b0, "R8 not idle");
        // R9: writes to read-only offsets ignored
        wr(5'h00, 32'hFFFF_FFFF); wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF_FFFF); wr(5'h1C, 32'hFFFF_FFFF);
        step(32'h8000_4000, 1'b1, "R9 ro write");
        // R2/R3/R5: directed steering
        wr(5'h04, 32'h8000_4000); wr(5'h08, 32'h8000_0000);
        step(32'h8000_4000, 1'b0, "R3 split");
        step(32'h0000_0000, 1'b1, "R4 drop");
        // random mix
        void'($urandom(32'd1234));
        for (int n = 0; n < 300; n++) begin
            if ($urandom % 4 == 0) wr(5'h04, $urandom);
            if ($urandom % 4 == 0) wr(5'h08, $urandom);
            if ($urandom % 8 == 0) wr(5'h14, $urandom);
            step($urandom & ($urandom | $urandom), 1'($urandom), "R5/R10 random");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule